// File: doc/BRIEF.md
# Shadow Register Set Status Controller

This block owns a processor's 32-bit status word and keeps it consistent while execution moves between the normal register set and a number of shadow register sets. Software reads the word and may rewrite most of its fields. Synchronous exceptions and external interrupts both enter through the block. An external interrupt controller presents requests that carry a priority level, a destination register set and a nonmaskable flag. The block decides whether each request is accepted and, in the same cycle, moves the register-set bookkeeping to the new context.

Every entry may save the previous set number and produce a snapshot of the status word. The exception or break status register stores that snapshot. An exception return puts the saved word back. The set numbers are kept only as wide as the configured number of register sets needs. A parameter selects a variant with memory management, in which a nested non-break exception does not overwrite the snapshot.

Top module: `rs_status_ctl`

## Requirements
- R1: Synchronous active-high reset sets the status word to 0x0080_0000. Only the register-set interrupt-enable bit (bit 23) is 1. The current and previous set numbers are 0, and the snapshot strobe is low.
- R2: A software write stores bit 0 (interrupt enable), bit 1 (user), bit 2 (exception-handler flag), bit 3 (interrupt-handler flag), the level in bits 9:4, the previous set in bits 21:16, the nonmaskable flag in bit 22 and the register-set interrupt enable in bit 23. With 4 register sets, writing 0xFFFF_FFFF from reset reads back 0x00C3_03FF. The previous set field keeps only its low 2 bits, and bits 31:24 read as 0.
- R3: Software writes never change the current set field (bits 15:10).
- R4: On an entry that saves context, the previous set takes the old current set. The snapshot output then carries the status word with that new previous set, and the snapshot strobe is high for exactly the cycle after the entry.
- R5: With memory management enabled, a non-break exception that arrives while bit 2 is 1 leaves the previous set unchanged and raises no snapshot strobe. A break exception always saves context.
- R6: A synchronous exception sets the current set to 0.
- R7: A maskable request is accepted only when bit 0 is 1 and its level is strictly greater than the level field.
- R8: When bit 23 is 0, a request whose target set equals the current set is refused. When bit 23 is 1, such a request is allowed.
- R9: An accepted interrupt loads the current set with the request's target set, moves the old current set into the previous set and clears bit 0, all at one clock edge.
- R10: A nonmaskable request ignores bit 0 and the level field, and its acceptance sets bit 22.
- R11: An exception return reloads the whole status word, including the current set, from the supplied word. Unimplemented bits are cleared.
- R12: Exception return takes priority over a synchronous exception, a synchronous exception over an interrupt, and an interrupt over a software write. The accept output is low while a return or an exception is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_we | input | 1 | Software write strobe |
| sw_wdata | input | 32 | Software write data |
| ret_valid | input | 1 | Exception return strobe |
| ret_word | input | 32 | Status word to restore on return |
| exc_valid | input | 1 | Synchronous exception entry |
| exc_break | input | 1 | The exception is a break |
| irq_req | input | 1 | External interrupt request present |
| irq_level | input | 6 | Requested interrupt level |
| irq_set | input | 6 | Requested register set |
| irq_nmi | input | 1 | Request is nonmaskable |
| irq_accept | output | 1 | Request accepted this cycle |
| status_rd | output | 32 | Current status word |
| cur_set | output | SET_W | Current register set |
| prev_set | output | SET_W | Previous register set |
| saved_status | output | 32 | Snapshot for the saved-status register |
| saved_we | output | 1 | Snapshot strobe |

## Verification
The acceptance decision is tried with requests whose level is above, equal to and below the level field. Those cases separate a strict comparison from an inclusive one. Further requests arrive with interrupts disabled, with a target equal to or different from the current set under both settings of bit 23, and as nonmaskable requests. These cases show which gates apply to which kind of request. Two nested interrupts to different sets, followed by an exception, show that the previous set and the snapshot follow the old current set at each level. Simultaneous return, exception and interrupt inputs confirm the priority order.

// File: rtl/rs_status_pkg.sv
package rs_status_pkg;
  localparam int unsigned FLD_W   = 6;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned B_PIE   = 0;
  localparam int unsigned B_EH    = 2;
  localparam int unsigned B_NMI   = 22;
  localparam int unsigned B_RSIE  = 23;

  // Packed order places every field at its architectural bit position.
  typedef struct packed {
    logic             rsie;
    logic             nmi;
    logic [FLD_W-1:0] prs;
    logic [FLD_W-1:0] crs;
    logic [FLD_W-1:0] il;
    logic             ih;
    logic             eh;
    logic             u;
    logic             pie;
  } status_t;

  localparam status_t STATUS_RST = '{rsie: 1'b1, default: '0};

  function automatic logic [WORD_W-1:0] pack_status(input status_t s);
    return {8'h00, s};
  endfunction
endpackage

// File: rtl/rs_word_mask.sv
module rs_word_mask
  import rs_status_pkg::*;
#(
  parameter int SET_W    = 2,
  parameter bit HAS_RSIE = 1'b1
) (
  input  logic [WORD_W-1:0] word,
  output status_t           fields
);
  localparam logic [FLD_W-1:0] SMASK = FLD_W'((1 << SET_W) - 1);

  status_t raw;
  assign raw = status_t'(word[23:0]);

  always_comb begin
    fields      = raw;
    fields.prs  = raw.prs & SMASK;
    fields.crs  = raw.crs & SMASK;
    fields.rsie = HAS_RSIE ? raw.rsie : 1'b1;
  end
endmodule

// File: rtl/rs_irq_gate.sv
module rs_irq_gate
  import rs_status_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  status_t          st,
  input  logic             req,
  input  logic [FLD_W-1:0] level,
  input  logic [FLD_W-1:0] tgt,
  input  logic             nmi,
  input  logic             blocked,
  output logic             take
);
  logic set_ok;
  logic lvl_ok;

  assign set_ok = st.rsie | (tgt != st.crs);
  assign lvl_ok = nmi | (st.pie & (level > st.il));
  assign take   = req & ~blocked & set_ok & lvl_ok;

  a_r7_level_gate: assert property (@(posedge clk) disable iff (rst)
    (take && !nmi) |-> (st.pie && level > st.il));
  a_r8_same_set_block: assert property (@(posedge clk) disable iff (rst)
    (take && !st.rsie) |-> (tgt != st.crs));
  a_r12_no_take_when_blocked: assert property (@(posedge clk) disable iff (rst)
    blocked |-> !take);
endmodule

// File: rtl/rs_status_core.sv
module rs_status_core
  import rs_status_pkg::*;
#(
  parameter int SET_W   = 2,
  parameter bit HAS_MMU = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sw_we,
  input  status_t           sw_fields,
  input  logic              ret_valid,
  input  status_t           ret_fields,
  input  logic              exc_valid,
  input  logic              exc_break,
  input  logic              irq_take,
  input  logic [FLD_W-1:0]  irq_set,
  input  logic              irq_nmi,
  output status_t           st_q,
  output logic [WORD_W-1:0] saved_q,
  output logic              saved_we_q
);
  localparam logic [FLD_W-1:0] SMASK = FLD_W'((1 << SET_W) - 1);

  status_t           st_d;
  status_t           snap;
  logic [WORD_W-1:0] saved_d;
  logic              saved_we_d;
  logic              entry;
  logic              is_brk;
  logic              save_ctx;

  assign entry    = ~ret_valid & (exc_valid | irq_take);
  assign is_brk   = exc_valid & exc_break;
  assign save_ctx = entry & (~HAS_MMU | is_brk | ~st_q.eh);

  always_comb begin
    snap     = st_q;
    snap.prs = st_q.crs;
  end

  always_comb begin
    st_d       = st_q;
    saved_d    = saved_q;
    saved_we_d = 1'b0;
    if (ret_valid) begin
      st_d = ret_fields;
    end else if (entry) begin
      if (save_ctx) begin
        st_d.prs   = st_q.crs;
        saved_d    = pack_status(snap);
        saved_we_d = 1'b1;
      end
      if (exc_valid) begin
        st_d.crs = '0;
      end else begin
        st_d.crs = irq_set & SMASK;
        st_d.pie = 1'b0;
        if (irq_nmi) st_d.nmi = 1'b1;
      end
    end else if (sw_we) begin
      st_d     = sw_fields;
      st_d.crs = st_q.crs;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= STATUS_RST;
      saved_q    <= '0;
      saved_we_q <= 1'b0;
    end else begin
      st_q       <= st_d;
      saved_q    <= saved_d;
      saved_we_q <= saved_we_d;
    end
  end

  a_r3_crs_readonly: assert property (@(posedge clk) disable iff (rst)
    (sw_we && !ret_valid && !exc_valid && !irq_take) |=> $stable(st_q.crs));
  a_r6_exc_clears_crs: assert property (@(posedge clk) disable iff (rst)
    (exc_valid && !ret_valid) |=> (st_q.crs == '0));
  a_r4_prs_follows_crs: assert property (@(posedge clk) disable iff (rst)
    (save_ctx) |=> (saved_we_q && st_q.prs == $past(st_q.crs)));
  a_r10_nmi_sets_flag: assert property (@(posedge clk) disable iff (rst)
    (irq_take && irq_nmi && !ret_valid && !exc_valid) |=> st_q.nmi);
  a_r11_return_reload: assert property (@(posedge clk) disable iff (rst)
    ret_valid |=> (st_q == $past(ret_fields)));
  a_r9_target_loaded: assert property (@(posedge clk) disable iff (rst)
    (irq_take && !ret_valid && !exc_valid) |=> (st_q.crs == $past(irq_set & SMASK) && !st_q.pie));
endmodule

// File: rtl/rs_status_ctl.sv
module rs_status_ctl
  import rs_status_pkg::*;
#(
  parameter int NUM_SETS = 4,
  parameter bit HAS_MMU  = 1'b0,
  parameter bit HAS_RSIE = 1'b1,
  parameter int SET_W    = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sw_we,
  input  logic [31:0]       sw_wdata,
  input  logic              ret_valid,
  input  logic [31:0]       ret_word,
  input  logic              exc_valid,
  input  logic              exc_break,
  input  logic              irq_req,
  input  logic [5:0]        irq_level,
  input  logic [5:0]        irq_set,
  input  logic              irq_nmi,
  output logic              irq_accept,
  output logic [31:0]       status_rd,
  output logic [SET_W-1:0]  cur_set,
  output logic [SET_W-1:0]  prev_set,
  output logic [31:0]       saved_status,
  output logic              saved_we
);
  status_t sw_fields;
  status_t ret_fields;
  status_t st_q;
  logic    take;

  rs_word_mask #(.SET_W(SET_W), .HAS_RSIE(HAS_RSIE)) u_sw_mask (
    .word(sw_wdata), .fields(sw_fields));

  rs_word_mask #(.SET_W(SET_W), .HAS_RSIE(HAS_RSIE)) u_ret_mask (
    .word(ret_word), .fields(ret_fields));

  rs_irq_gate u_gate (
    .clk(clk), .rst(rst), .st(st_q), .req(irq_req), .level(irq_level),
    .tgt(irq_set), .nmi(irq_nmi), .blocked(ret_valid | exc_valid), .take(take));

  rs_status_core #(.SET_W(SET_W), .HAS_MMU(HAS_MMU)) u_core (
    .clk(clk), .rst(rst), .sw_we(sw_we), .sw_fields(sw_fields),
    .ret_valid(ret_valid), .ret_fields(ret_fields), .exc_valid(exc_valid),
    .exc_break(exc_break), .irq_take(take), .irq_set(irq_set),
    .irq_nmi(irq_nmi), .st_q(st_q), .saved_q(saved_status),
    .saved_we_q(saved_we));

  assign irq_accept = take;
  assign status_rd  = pack_status(st_q);
  assign cur_set    = st_q.crs[SET_W-1:0];
  assign prev_set   = st_q.prs[SET_W-1:0];

  initial begin
    a_r2_set_count: assert (NUM_SETS >= 1 && NUM_SETS <= 64);
  end
endmodule

// File: tb/rs_status_ctl_bench.sv
module rs_status_ctl_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sw_we = 0, ret_valid = 0, exc_valid = 0, exc_break = 0;
  logic        irq_req = 0, irq_nmi = 0;
  logic [31:0] sw_wdata = '0, ret_word = '0;
  logic [5:0]  irq_level = '0, irq_set = '0;
  logic        acc, sv_we, m_acc, m_sv_we;
  logic [31:0] st, sv, m_st, m_sv;
  logic [1:0]  cur, prev, m_cur, m_prev;
  int          total = 0, bad = 0;

  always #4 clk = ~clk;

  rs_status_ctl u_rs_status_ctl (
    .clk(clk), .rst(rst), .sw_we(sw_we), .sw_wdata(sw_wdata),
    .ret_valid(ret_valid), .ret_word(ret_word), .exc_valid(exc_valid),
    .exc_break(exc_break), .irq_req(irq_req), .irq_level(irq_level),
    .irq_set(irq_set), .irq_nmi(irq_nmi), .irq_accept(acc), .status_rd(st),
    .cur_set(cur), .prev_set(prev), .saved_status(sv), .saved_we(sv_we));

  rs_status_ctl #(.HAS_MMU(1'b1)) u_rs_status_ctl_mmu (
    .clk(clk), .rst(rst), .sw_we(sw_we), .sw_wdata(sw_wdata),
    .ret_valid(ret_valid), .ret_word(ret_word), .exc_valid(exc_valid),
    .exc_break(exc_break), .irq_req(irq_req), .irq_level(irq_level),
    .irq_set(irq_set), .irq_nmi(irq_nmi), .irq_accept(m_acc), .status_rd(m_st),
    .cur_set(m_cur), .prev_set(m_prev), .saved_status(m_sv), .saved_we(m_sv_we));

  // {pie, il[5:0], crs[1:0], rsie, level[5:0], set[1:0], nmi, expect_accept}
  localparam int NV = 10;
  localparam logic [19:0] VEC [NV] = '{
    {1'b1, 6'd3,  2'd0, 1'b1, 6'd4,  2'd1, 1'b0, 1'b1},
    {1'b1, 6'd3,  2'd0, 1'b1, 6'd3,  2'd1, 1'b0, 1'b0},
    {1'b1, 6'd3,  2'd0, 1'b1, 6'd2,  2'd1, 1'b0, 1'b0},
    {1'b0, 6'd0,  2'd0, 1'b1, 6'd5,  2'd1, 1'b0, 1'b0},
    {1'b1, 6'd0,  2'd2, 1'b0, 6'd1,  2'd2, 1'b0, 1'b0},
    {1'b1, 6'd0,  2'd2, 1'b1, 6'd1,  2'd2, 1'b0, 1'b1},
    {1'b1, 6'd0,  2'd2, 1'b0, 6'd1,  2'd1, 1'b0, 1'b1},
    {1'b0, 6'd63, 2'd1, 1'b1, 6'd0,  2'd3, 1'b1, 1'b1},
    {1'b0, 6'd63, 2'd1, 1'b0, 6'd0,  2'd1, 1'b1, 1'b0},
    {1'b1, 6'd62, 2'd0, 1'b1, 6'd63, 2'd3, 1'b0, 1'b1}
  };

  function automatic logic [31:0] mkw(input logic pie, input logic [5:0] il,
                                      input logic [1:0] crs, input logic rsie);
    return (32'(rsie) << 23) | (32'(crs) << 10) | (32'(il) << 4) | 32'(pie);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    sw_we = 0; ret_valid = 0; exc_valid = 0; exc_break = 0; irq_req = 0; irq_nmi = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=0x%08h expected=0x%08h", 32'd0, 32'd1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk); tick(); tick();
    rst = 0;
    chk(st == 32'h0080_0000, "R1 reset word", st, 32'h0080_0000);
    chk(cur == 0 && prev == 0 && !sv_we, "R1 reset sets", {cur, prev, sv_we}, 0);

    // R7 R8 R9 R10 table walk
    for (int i = 0; i < NV; i++) begin
      logic [19:0] v = VEC[i];
      ret_valid = 1; ret_word = mkw(v[19], v[18:13], v[12:11], v[10]);
      tick(); idle();
      irq_req = 1; irq_level = v[9:4]; irq_set = {4'd0, v[3:2]}; irq_nmi = v[1];
      #1;
      chk(acc == v[0], "R7 R8 R10 accept", 32'(acc), 32'(v[0]));
      tick(); idle();
      chk(cur == (v[0] ? v[3:2] : v[12:11]), "R9 current set", 32'(cur),
          32'(v[0] ? v[3:2] : v[12:11]));
      chk(prev == (v[0] ? v[12:11] : 2'd0), "R9 previous set", 32'(prev),
          32'(v[0] ? v[12:11] : 2'd0));
      chk(st[0] == (v[0] ? 1'b0 : v[19]), "R9 enable cleared", 32'(st[0]),
          32'(v[0] ? 1'b0 : v[19]));
      if (v[1] && v[0]) chk(st[22], "R10 nmi flag", st, 32'h0040_0000);
    end

    // R2 write mask from reset
    rst = 1; tick(); rst = 0;
    sw_we = 1; sw_wdata = 32'hFFFF_FFFF; tick(); idle();
    chk(st == 32'h00C3_03FF, "R2 write mask", st, 32'h00C3_03FF);

    // R3 current set ignores writes
    ret_valid = 1; ret_word = 32'h0080_0800; tick(); idle();
    sw_we = 1; sw_wdata = 32'h0080_0000; tick(); idle();
    chk(st == 32'h0080_0800, "R3 crs read-only", st, 32'h0080_0800);

    // R4 R9 nested interrupts then exception (R6)
    rst = 1; tick(); rst = 0;
    sw_we = 1; sw_wdata = 32'h0080_0001; tick(); idle();
    irq_req = 1; irq_level = 6'd5; irq_set = 6'd1; tick(); idle();
    chk(st == 32'h0080_0400, "R9 first nest", st, 32'h0080_0400);
    chk(sv_we && sv == 32'h0080_0001, "R4 first snapshot", sv, 32'h0080_0001);
    sw_we = 1; sw_wdata = 32'h0080_0001; tick(); idle();
    chk(!sv_we, "R4 strobe one cycle", 32'(sv_we), 0);
    irq_req = 1; irq_level = 6'd6; irq_set = 6'd2; tick(); idle();
    chk(st == 32'h0081_0800, "R9 second nest", st, 32'h0081_0800);
    chk(sv_we && sv == 32'h0081_0401, "R4 second snapshot", sv, 32'h0081_0401);
    exc_valid = 1; tick(); idle();
    chk(st == 32'h0082_0000 && cur == 0, "R6 exception crs zero", st, 32'h0082_0000);
    chk(sv_we && sv == 32'h0082_0800, "R4 exception snapshot", sv, 32'h0082_0800);

    // R12 priority
    ret_valid = 1; ret_word = 32'h0080_0801; exc_valid = 1;
    irq_req = 1; irq_level = 6'd5; irq_set = 6'd1; #1;
    chk(!acc, "R12 accept low on return", 32'(acc), 0);
    tick(); idle();
    chk(st == 32'h0080_0801, "R12 return wins", st, 32'h0080_0801);
    exc_valid = 1; irq_req = 1; irq_level = 6'd5; irq_set = 6'd1; #1;
    chk(!acc, "R12 accept low on exception", 32'(acc), 0);
    tick(); idle();
    chk(st == 32'h0082_0001, "R12 exception over irq", st, 32'h0082_0001);

    // R5 memory-management variant
    ret_valid = 1; ret_word = 32'h0080_0804; tick(); idle();
    exc_valid = 1; tick(); idle();
    chk(!m_sv_we && m_prev == 0 && m_cur == 0, "R5 nested no save",
        {m_sv_we, m_prev, m_cur}, 0);
    ret_valid = 1; ret_word = 32'h0080_0804; tick(); idle();
    exc_valid = 1; exc_break = 1; tick(); idle();
    chk(m_sv_we && m_prev == 2, "R5 break saves", {m_sv_we, m_prev}, 32'h6);

    // R11 full reload with masking
    ret_valid = 1; ret_word = 32'hFFFF_FFFF; tick(); idle();
    chk(st == 32'h00C3_0FFF && cur == 3, "R11 return reload", st, 32'h00C3_0FFF);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule